// File: doc/BRIEF.md
# Phase-Frequency Detector with Frequency Steering and Lock Flag

This block compares two event streams that are synchronous to a fast system clock. The first is a feedback stream on the plus input and the second is a reference stream on the minus input. It produces a three-level drive code that is meant for a later loop filter. The code is high when the feedback runs ahead, low when it runs behind, and mid (weakly driven) otherwise.

A ten-state machine tracks the two streams. In phase-only operation the drive pulses for exactly the gap between the two edges. When a frequency difference persists, the machine climbs into deeper states and pins the drive fully high or fully low until the slower stream catches up. This gives fast pull-in. A lock flag is decoded from the state and reads 1 only while no frequency error exists.

Both inputs pass through two-flop synchronizers and are then edge-detected. A double-edge mode makes the feedback input count both of its transitions. This doubles its effective event rate.

Top module: `pfd_steer`

## Requirements
- R1: Each input is synchronized and edge-detected. A level change on an input can change `drive` only after the third rising clock edge that follows it. A falling transition is never an event on `ref_in`, and it is an event on `fb_in` only when `dbl_en` is 1.
- R2: `drive` encoding: 2'b10 drives high, 2'b01 drives low, 2'b00 is the mid level. 2'b11 never appears.
- R3: While `rst_n` is low, and after it is released, the machine sits in the positive-side idle state. In that state `drive` is 2'b00 and `locked` is 1.
- R4: With equal periods and the feedback leading, `drive` is high for exactly as many cycles as the gap from the feedback edge to the reference edge. It is mid for the rest of each period and never low.
- R5: With equal periods and the reference leading, `drive` is low for exactly the gap between the edges. It is mid otherwise and never high.
- R6: When feedback events persistently outnumber reference events, `drive` settles to a constant 2'b10 and `locked` to 0.
- R7: When reference events persistently outnumber feedback events, `drive` settles to a constant 2'b01 and `locked` to 0.
- R8: State behaviour, with plus events first and minus events second:
  - positive idle (mid): plus goes to lead, minus goes to lag.
  - negative idle (mid): plus goes to lead, minus goes to lag.
  - lead (high): plus goes to fast-A, minus goes to positive idle.
  - fast-A (high): plus goes to fast-B, minus goes to positive crossover.
  - fast-B (high): plus stays, minus goes to fast-A.
  - positive crossover (high): plus goes to fast-A, minus goes to positive idle.
  - lag (low): plus goes to negative idle, minus goes to slow-A.
  - slow-A (low): plus goes to negative crossover, minus goes to slow-B.
  - slow-B (low): plus goes to slow-A, minus stays.
  - negative crossover (low): plus goes to negative idle, minus goes to slow-A.
- R9: `locked` is 1 exactly in the two idle states, lead and lag. It is 0 in the fast, slow and crossover states.
- R10: A plus event and a minus event in the same clock cycle cancel, and the state does not change.
- R11: With `dbl_en` at 1, a falling transition of `fb_in` acts as a plus event, exactly like a rising one.
- R12: The deepest states saturate. A further plus event in fast-B, or a further minus event in slow-B, leaves the state and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_in | input | 1 | Feedback (plus) event stream |
| ref_in | input | 1 | Reference (minus) event stream |
| dbl_en | input | 1 | 1: both transitions of `fb_in` are events |
| drive | output | 2 | 2'b10 high, 2'b01 low, 2'b00 mid |
| locked | output | 1 | 1 when no frequency error is present |

## Verification
An input change reaches `drive` and `locked` on the third rising edge after it: two synchronizer stages, then the state register. The directed tests change the inputs on a falling edge and read the outputs three falling edges later. They do this once per event, walking the state table, which leaves no ambiguity about which edge was counted. The waveform tests sample each cycle before driving that cycle's input levels. The high or low run therefore appears shifted by three cycles, but its length equals the edge gap exactly. For the frequency-error cases, counting starts only after a settling window that is longer than the steering climb.

// File: rtl/pfd_steer.sv
module pfd_steer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_in,
  input  logic       ref_in,
  input  logic       dbl_en,
  output logic [1:0] drive,
  output logic       locked
);
  localparam int SW = SYNC_STAGES + 1;
  localparam logic [1:0] DRV_MID  = 2'b00;
  localparam logic [1:0] DRV_LOW  = 2'b01;
  localparam logic [1:0] DRV_HIGH = 2'b10;

  typedef enum logic [3:0] {
    ST_IDLE_N = 4'd1, ST_LAG    = 4'd2, ST_SLOW_A = 4'd3, ST_SLOW_B = 4'd4,
    ST_XN     = 4'd5, ST_IDLE_P = 4'd6, ST_LEAD   = 4'd7, ST_FAST_A = 4'd8,
    ST_FAST_B = 4'd9, ST_XP     = 4'd10
  } st_t;

  logic [SW-1:0] fb_sh, ref_sh;
  logic ev_p, ev_m;
  st_t  state, nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fb_sh  <= '0;
      ref_sh <= '0;
    end else begin
      fb_sh  <= {fb_sh[SW-2:0], fb_in};
      ref_sh <= {ref_sh[SW-2:0], ref_in};
    end

  assign ev_p = dbl_en ? (fb_sh[SW-2] ^ fb_sh[SW-1]) : (fb_sh[SW-2] & ~fb_sh[SW-1]);
  assign ev_m = ref_sh[SW-2] & ~ref_sh[SW-1];

  function automatic st_t on_plus(input st_t s);
    case (s)
      ST_IDLE_N, ST_IDLE_P: on_plus = ST_LEAD;
      ST_LEAD:              on_plus = ST_FAST_A;
      ST_FAST_A:            on_plus = ST_FAST_B;
      ST_FAST_B:            on_plus = ST_FAST_B;
      ST_XP:                on_plus = ST_FAST_A;
      ST_LAG:               on_plus = ST_IDLE_N;
      ST_SLOW_A:            on_plus = ST_XN;
      ST_SLOW_B:            on_plus = ST_SLOW_A;
      ST_XN:                on_plus = ST_IDLE_N;
      default:              on_plus = ST_IDLE_P;
    endcase
  endfunction

  function automatic st_t on_minus(input st_t s);
    case (s)
      ST_IDLE_N, ST_IDLE_P: on_minus = ST_LAG;
      ST_LAG:               on_minus = ST_SLOW_A;
      ST_SLOW_A:            on_minus = ST_SLOW_B;
      ST_SLOW_B:            on_minus = ST_SLOW_B;
      ST_XN:                on_minus = ST_SLOW_A;
      ST_LEAD:              on_minus = ST_IDLE_P;
      ST_FAST_A:            on_minus = ST_XP;
      ST_FAST_B:            on_minus = ST_FAST_A;
      ST_XP:                on_minus = ST_IDLE_P;
      default:              on_minus = ST_IDLE_P;
    endcase
  endfunction

  always_comb begin
    nxt = state;
    if (ev_p && !ev_m)      nxt = on_plus(state);
    else if (ev_m && !ev_p) nxt = on_minus(state);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_IDLE_P;
    else        state <= nxt;

  always_comb begin
    case (state)
      ST_LEAD, ST_FAST_A, ST_FAST_B, ST_XP: drive = DRV_HIGH;
      ST_LAG, ST_SLOW_A, ST_SLOW_B, ST_XN:  drive = DRV_LOW;
      default:                              drive = DRV_MID;
    endcase
  end

  assign locked = (state == ST_IDLE_N) || (state == ST_IDLE_P) ||
                  (state == ST_LEAD)   || (state == ST_LAG);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state inside {ST_IDLE_N, ST_LAG, ST_SLOW_A, ST_SLOW_B, ST_XN,
                  ST_IDLE_P, ST_LEAD, ST_FAST_A, ST_FAST_B, ST_XP}); // R8
  AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_p && !ev_m) |=> $stable(state)); // R1
  AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_p && ev_m) |=> $stable(state)); // R10
  AST_MID_IS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (drive == DRV_MID) |-> locked); // R9
  AST_HIGH_FROM_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive == DRV_HIGH) |-> $past(ev_p && !ev_m)); // R4
  AST_LOW_FROM_MINUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive == DRV_LOW) |-> $past(ev_m && !ev_p)); // R5
  AST_DRIVE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    drive != 2'b11); // R2
endmodule

// File: tb/test_pfd_steer.sv
`timescale 1ns/1ps
module test_pfd_steer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_in = 1'b0, ref_in = 1'b0, dbl_en = 1'b0;
  logic [1:0] drive;
  logic locked;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  localparam logic [1:0] HI = 2'b10, LO = 2'b01, MID = 2'b00;

  pfd_steer i_pfd_steer (.clk(clk), .rst_n(rst_n), .fb_in(fb_in), .ref_in(ref_in),
                         .dbl_en(dbl_en), .drive(drive), .locked(locked));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [1:0] d_exp, input logic l_exp);
    n_chk++;
    if (drive !== d_exp || locked !== l_exp) begin
      n_err++;
      $display("FAIL %s: drive=%b locked=%b expected drive=%b locked=%b",
               tag, drive, locked, d_exp, l_exp);
    end
  endtask

  task automatic chk_cnt(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_err++;
      $display("FAIL %s: count=%0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic do_reset(input logic dbl);
    @(negedge clk);
    rst_n = 1'b0; fb_in = 1'b0; ref_in = 1'b0; dbl_en = dbl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input logic f, input logic r);
    @(negedge clk);
    fb_in = f; ref_in = r;
    repeat (3) @(negedge clk);
  endtask

  task automatic plus_ev(input string tag, input logic [1:0] d_exp, input logic l_exp);
    step(1'b1, 1'b0); chk(tag, d_exp, l_exp); step(1'b0, 1'b0);
  endtask

  task automatic minus_ev(input string tag, input logic [1:0] d_exp, input logic l_exp);
    step(1'b0, 1'b1); chk(tag, d_exp, l_exp); step(1'b0, 1'b0);
  endtask

  task automatic run_wave(input int fp, input int fa, input int rp, input int ra,
                          input int total, input int skip,
                          output int n_hi, output int n_lo, output int n_unl);
    n_hi = 0; n_lo = 0; n_unl = 0;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (i >= skip) begin
        if (drive == HI) n_hi++;
        if (drive == LO) n_lo++;
        if (!locked)     n_unl++;
      end
      fb_in  = ((i % fp) >= fa) && ((i % fp) < fa + 2);
      ref_in = ((i % rp) >= ra) && ((i % rp) < ra + 2);
    end
    fb_in = 1'b0; ref_in = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 during reset", MID, 1'b1);
    do_reset(1'b0);
    chk("R3 after reset", MID, 1'b1);
  endtask

  task automatic t_latency;
    do_reset(1'b0);
    @(negedge clk); fb_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no change after two edges", MID, 1'b1);
    @(negedge clk);
    chk("R1 change on third edge", HI, 1'b1);
    step(1'b1, 1'b1);
    chk("R2 minus edge returns to mid code 00", MID, 1'b1);
    step(1'b0, 1'b1);
    chk("R1 falling fb ignored with dbl_en=0", MID, 1'b1);
    step(1'b0, 1'b0);
    chk("R1 falling ref ignored", MID, 1'b1);
  endtask

  task automatic t_walk;
    do_reset(1'b0);
    plus_ev ("R8 idle_p+ -> lead",       HI,  1'b1);
    plus_ev ("R8 lead+ -> fast_a",       HI,  1'b0);
    plus_ev ("R8 fast_a+ -> fast_b",     HI,  1'b0);
    plus_ev ("R12 fast_b+ saturates",    HI,  1'b0);
    minus_ev("R8 fast_b- -> fast_a",     HI,  1'b0);
    minus_ev("R8 fast_a- -> xp",         HI,  1'b0);
    plus_ev ("R8 xp+ -> fast_a",         HI,  1'b0);
    minus_ev("R8 fast_a- -> xp again",   HI,  1'b0);
    minus_ev("R9 xp- -> idle_p",         MID, 1'b1);
    minus_ev("R8 idle_p- -> lag",        LO,  1'b1);
    minus_ev("R9 lag- -> slow_a",        LO,  1'b0);
    minus_ev("R8 slow_a- -> slow_b",     LO,  1'b0);
    minus_ev("R12 slow_b- saturates",    LO,  1'b0);
    plus_ev ("R8 slow_b+ -> slow_a",     LO,  1'b0);
    plus_ev ("R8 slow_a+ -> xn",         LO,  1'b0);
    minus_ev("R8 xn- -> slow_a",         LO,  1'b0);
    plus_ev ("R8 slow_a+ -> xn again",   LO,  1'b0);
    plus_ev ("R9 xn+ -> idle_n",         MID, 1'b1);
    plus_ev ("R8 idle_n+ -> lead",       HI,  1'b1);
    minus_ev("R8 lead- -> idle_p",       MID, 1'b1);
    minus_ev("R8 idle_p- -> lag",        LO,  1'b1);
    plus_ev ("R8 lag+ -> idle_n",        MID, 1'b1);
    minus_ev("R8 idle_n- -> lag",        LO,  1'b1);
  endtask

  task automatic t_cancel;
    do_reset(1'b0);
    step(1'b1, 1'b0); chk("R10 setup lead", HI, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1); chk("R10 simultaneous edges cancel", HI, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1); chk("R10 later minus still counted", MID, 1'b1);
  endtask

  task automatic t_double;
    do_reset(1'b1);
    step(1'b1, 1'b0); chk("R11 rising fb", HI, 1'b1);
    step(1'b1, 1'b1); chk("R11 ref edge", MID, 1'b1);
    step(1'b0, 1'b1); chk("R11 falling fb counts", HI, 1'b1);
    step(1'b0, 1'b0); chk("R11 falling ref ignored", HI, 1'b1);
  endtask

  task automatic t_lead;
    int h, l, u;
    do_reset(1'b0);
    run_wave(20, 2, 20, 7, 200, 0, h, l, u);
    chk_cnt("R4 high cycles leading", h, 50);
    chk_cnt("R4 no low when leading", l, 0);
    chk_cnt("R9 stays locked when leading", u, 0);
    repeat (4) @(negedge clk);
    chk("R4 ends mid", MID, 1'b1);
  endtask

  task automatic t_lag;
    int h, l, u;
    do_reset(1'b0);
    run_wave(20, 7, 20, 2, 200, 0, h, l, u);
    chk_cnt("R5 low cycles lagging", l, 50);
    chk_cnt("R5 no high when lagging", h, 0);
    chk_cnt("R9 stays locked when lagging", u, 0);
  endtask

  task automatic t_fast;
    int h, l, u;
    do_reset(1'b0);
    run_wave(7, 0, 10, 5, 240, 40, h, l, u);
    chk_cnt("R6 pinned high", h, 200);
    chk_cnt("R6 unlocked throughout", u, 200);
  endtask

  task automatic t_slow;
    int h, l, u;
    do_reset(1'b0);
    run_wave(10, 5, 7, 0, 240, 40, h, l, u);
    chk_cnt("R7 pinned low", l, 200);
    chk_cnt("R7 unlocked throughout", u, 200);
  endtask

  initial begin
    t_reset;
    t_latency;
    t_walk;
    t_cancel;
    t_double;
    t_lead;
    t_lag;
    t_fast;
    t_slow;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule